// File: doc/BRIEF.md
# Pin Test-Mode Selector with XNOR Connectivity Chains

This block sits between the functional core and the pad ring. It reads a 4-bit test-mode code and, on every pin it owns, either passes the core's value and enable straight through or replaces them with test values. Besides normal operation it offers three test modes. The first floats every pad driver except the crystal output. The second folds all dedicated input pins through an XNOR chain and drives the result onto every bidirectional pin. The third folds all bidirectional pins through a second chain and drives that result onto every output-only pin.

The mode is held in a small state machine. The state is HOLD while reset is asserted. On the first clock edge after reset is released, the machine takes one of the transitions HOLD→NORMAL, HOLD→FLOAT, HOLD→INTREE or HOLD→BIDITREE, chosen by the code on the test pins at that edge. It then stays in that state until reset is asserted again, which is the transition any→HOLD. A tester therefore sets the code first and then pulses reset.

Top module: `tmode_top`

## Requirements
- R1: In HOLD (reset low), and in NORMAL (code 0000 at release), every bidirectional and output-only pin drives the core's value and enable unchanged.
- R2: The state is chosen only at the first rising clock edge with reset high. Later changes to the code pins have no effect until reset is asserted and released again.
- R3: Code 0010 enters FLOAT. All bidirectional and output-only enables are 0, and the values still follow the core.
- R4: The crystal output follows the core's crystal value in every state, including FLOAT.
- R5: Code 0011 enters INTREE. All bidirectional enables are 1 and every bidirectional value equals the input chain result. The input chain takes 11 inputs, with the chain position given by the index: ded_in[0] bus-power-valid, [1] bus-powered, [2] disk-ready, [3] device IRQ, [4] IORDY, [5] DMA request, then rst_n, then ded_in[6] ATA enable, [7] drive-power-valid, [8] system IRQ, [9] eject.
- R6: In INTREE the output-only pins pass the core's values and enables.
- R7: Code 0100 enters BIDITREE. All bidirectional enables are 0, all output-only enables are 1, and every output-only value equals the bidirectional chain result. Bidirectional index 0–2 is GPIO0–2, index 3+d is data bit d, and index 19 is the serial-data pin. The chain order is GPIO0, GPIO1, GPIO2, data 7, 8, 6, 0, 5, 10, 4, 11, 3, 12, 2, 13, 1, 14, 9, 15, then serial data. The output-only index order is power-500, ATA reset, write strobe, read strobe, DMA ack, pull-up enable, chip select 0–1, address 0–2, low-power, serial clock.
- R8: The reserved codes 0001 and 0101–1111 enter NORMAL.
- R9: Each chain stage outputs XNOR(previous stage, its input). The stage before the first is constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also a chain input |
| tmode_code | input | 4 | Test-mode code from the test pins |
| ded_in | input | 10 | Dedicated input pins (excluding reset) |
| bidi_in | input | 20 | Bidirectional pad input values |
| core_bidi_out | input | 20 | Core values for bidirectional pins |
| core_bidi_oe | input | 20 | Core enables for bidirectional pins |
| core_outo_out | input | 13 | Core values for output-only pins |
| core_outo_oe | input | 13 | Core enables for output-only pins |
| core_xtal_out | input | 1 | Core crystal driver value |
| bidi_out | output | 20 | Bidirectional pad values |
| bidi_oe | output | 20 | Bidirectional pad enables |
| outo_out | output | 13 | Output-only pad values |
| outo_oe | output | 13 | Output-only pad enables |
| xtal_out | output | 1 | Crystal driver value |

## Verification
The hardest case to reach from the ports is a change of the code pins after the state has been chosen. This matters most for a move to 0010 without a reset pulse, which must leave the pins driven. The stimulus releases reset with one code and then switches the pins to a different code part-way through the run. Floating is then expected only after a later reset pulse. Reset is also reasserted in the middle of a tree mode to confirm the return to pass-through. Every other cycle carries fresh random data on every input, so that both chain results toggle.

// File: rtl/tmode_pkg.sv
package tmode_pkg;
    localparam int N_DED  = 10;
    localparam int N_DCH  = N_DED + 1;
    localparam int N_BIDI = 20;
    localparam int N_OUTO = 13;
    localparam int CODE_W = 4;
    localparam int RST_POS = 6;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_NORMAL,
        ST_FLOAT,
        ST_INTREE,
        ST_BIDITREE
    } tm_state_e;

    function automatic tm_state_e decode_code(input logic [CODE_W-1:0] c);
        case (c)
            4'b0010: decode_code = ST_FLOAT;
            4'b0011: decode_code = ST_INTREE;
            4'b0100: decode_code = ST_BIDITREE;
            default: decode_code = ST_NORMAL;
        endcase
    endfunction

    function automatic int bidi_src(input int k);
        case (k)
            0: bidi_src = 0;    1: bidi_src = 1;    2: bidi_src = 2;
            3: bidi_src = 10;   4: bidi_src = 11;   5: bidi_src = 9;
            6: bidi_src = 3;    7: bidi_src = 8;    8: bidi_src = 13;
            9: bidi_src = 7;    10: bidi_src = 14;  11: bidi_src = 6;
            12: bidi_src = 15;  13: bidi_src = 5;   14: bidi_src = 16;
            15: bidi_src = 4;   16: bidi_src = 17;  17: bidi_src = 12;
            18: bidi_src = 18;  default: bidi_src = 19;
        endcase
    endfunction
endpackage

// File: rtl/tmode_fsm.sv
module tmode_fsm
    import tmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output tm_state_e         state
);
    tm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:     state_d = decode_code(code);
            ST_NORMAL,
            ST_FLOAT,
            ST_INTREE,
            ST_BIDITREE: state_d = state_q;
            default:     state_d = ST_HOLD;
        endcase
    end

    assign state = state_q;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD) |=> $stable(state_q));

    // R8
    reserved_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && code == 4'b0001) |=> (state_q == ST_NORMAL));
endmodule

// File: rtl/xnor_chain.sv
module xnor_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] din,
    output logic         res
);
    logic [N:0] stage;
    assign stage[0] = 1'b1;
    for (genvar k = 0; k < N; k++) begin : g_stage
        assign stage[k+1] = ~(stage[k] ^ din[k]);
    end
    assign res = stage[N];
endmodule

// File: rtl/tmode_pinmux.sv
module tmode_pinmux
    import tmode_pkg::*;
(
    input  tm_state_e         state,
    input  logic              ded_res,
    input  logic              bidi_res,
    input  logic [N_BIDI-1:0] core_bidi_out,
    input  logic [N_BIDI-1:0] core_bidi_oe,
    input  logic [N_OUTO-1:0] core_outo_out,
    input  logic [N_OUTO-1:0] core_outo_oe,
    output logic [N_BIDI-1:0] bidi_out,
    output logic [N_BIDI-1:0] bidi_oe,
    output logic [N_OUTO-1:0] outo_out,
    output logic [N_OUTO-1:0] outo_oe
);
    always_comb begin
        bidi_out = core_bidi_out;
        bidi_oe  = core_bidi_oe;
        outo_out = core_outo_out;
        outo_oe  = core_outo_oe;
        unique case (state)
            ST_HOLD, ST_NORMAL: ;
            ST_FLOAT: begin
                bidi_oe = '0;
                outo_oe = '0;
            end
            ST_INTREE: begin
                bidi_out = {N_BIDI{ded_res}};
                bidi_oe  = '1;
            end
            ST_BIDITREE: begin
                bidi_oe  = '0;
                outo_out = {N_OUTO{bidi_res}};
                outo_oe  = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tmode_top.sv
module tmode_top
    import tmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmode_code,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_BIDI-1:0] bidi_in,
    input  logic [N_BIDI-1:0] core_bidi_out,
    input  logic [N_BIDI-1:0] core_bidi_oe,
    input  logic [N_OUTO-1:0] core_outo_out,
    input  logic [N_OUTO-1:0] core_outo_oe,
    input  logic              core_xtal_out,
    output logic [N_BIDI-1:0] bidi_out,
    output logic [N_BIDI-1:0] bidi_oe,
    output logic [N_OUTO-1:0] outo_out,
    output logic [N_OUTO-1:0] outo_oe,
    output logic              xtal_out
);
    tm_state_e         state;
    logic [N_DCH-1:0]  ded_vec;
    logic [N_BIDI-1:0] bidi_vec;
    logic              ded_res, bidi_res;

    assign ded_vec = {ded_in[N_DED-1:RST_POS], rst_n, ded_in[RST_POS-1:0]};

    for (genvar k = 0; k < N_BIDI; k++) begin : g_bidi_order
        assign bidi_vec[k] = bidi_in[bidi_src(k)];
    end

    tmode_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (tmode_code),
        .state (state)
    );

    xnor_chain #(.N(N_DCH)) u_ded_chain (
        .din (ded_vec),
        .res (ded_res)
    );

    xnor_chain #(.N(N_BIDI)) u_bidi_chain (
        .din (bidi_vec),
        .res (bidi_res)
    );

    tmode_pinmux u_mux (
        .state         (state),
        .ded_res       (ded_res),
        .bidi_res      (bidi_res),
        .core_bidi_out (core_bidi_out),
        .core_bidi_oe  (core_bidi_oe),
        .core_outo_out (core_outo_out),
        .core_outo_oe  (core_outo_oe),
        .bidi_out      (bidi_out),
        .bidi_oe       (bidi_oe),
        .outo_out      (outo_out),
        .outo_oe       (outo_oe)
    );

    assign xtal_out = core_xtal_out;

    // R3
    float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAT) |-> (bidi_oe == '0 && outo_oe == '0));

    // R5
    intree_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTREE) |-> (bidi_oe == '1 && (bidi_out == '0 || bidi_out == '1)));

    // R7
    biditree_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIDITREE) |-> (outo_oe == '1 && bidi_oe == '0
                                     && (outo_out == '0 || outo_out == '1)));

    // R1
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL) |-> (bidi_oe == core_bidi_oe && outo_oe == core_outo_oe));
endmodule

// File: tb/test_tmode_top.sv
module test_tmode_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tmode_code = 4'b0000;
    logic [9:0]  ded_in = '0;
    logic [19:0] bidi_in = '0;
    logic [19:0] core_bidi_out = '0, core_bidi_oe = '0;
    logic [12:0] core_outo_out = '0, core_outo_oe = '0;
    logic        core_xtal_out = 1'b0;
    logic [19:0] bidi_out, bidi_oe;
    logic [12:0] outo_out, outo_oe;
    logic        xtal_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state: latched code, and whether the code has been taken since reset
    int  m_code = 0;
    bit  m_taken = 0;

    always #2 clk = ~clk;

    tmode_top i_tmode_top (
        .clk(clk), .rst_n(rst_n), .tmode_code(tmode_code), .ded_in(ded_in),
        .bidi_in(bidi_in), .core_bidi_out(core_bidi_out), .core_bidi_oe(core_bidi_oe),
        .core_outo_out(core_outo_out), .core_outo_oe(core_outo_oe),
        .core_xtal_out(core_xtal_out), .bidi_out(bidi_out), .bidi_oe(bidi_oe),
        .outo_out(outo_out), .outo_oe(outo_oe), .xtal_out(xtal_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_taken <= 0;
        else if (!m_taken) begin
            m_code  <= int'(tmode_code);
            m_taken <= 1;
        end
    end

    function automatic bit ded_chain();
        bit s = 1;
        bit v [11];
        for (int i = 0; i < 6; i++) v[i] = ded_in[i];
        v[6] = rst_n;
        for (int i = 6; i < 10; i++) v[i+1] = ded_in[i];
        for (int i = 0; i < 11; i++) s = !(s ^ v[i]);
        return s;
    endfunction

    function automatic bit bidi_chain();
        int ord [20] = '{0, 1, 2, 10, 11, 9, 3, 8, 13, 7, 14, 6, 15, 5, 16, 4, 17, 12, 18, 19};
        bit s = 1;
        for (int i = 0; i < 20; i++) s = !(s ^ bidi_in[ord[i]]);
        return s;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [19:0] eb_out, eb_oe;
        logic [12:0] eo_out, eo_oe;
        string tag;
        int mode = (m_taken && rst_n) ? m_code : 0;
        eb_out = core_bidi_out; eb_oe = core_bidi_oe;
        eo_out = core_outo_out; eo_oe = core_outo_oe;
        if (mode == 2) begin
            eb_oe = '0; eo_oe = '0; tag = "R3";
        end else if (mode == 3) begin
            eb_out = {20{ded_chain()}}; eb_oe = '1; tag = "R5/R9";
        end else if (mode == 4) begin
            eb_oe = '0; eo_out = {13{bidi_chain()}}; eo_oe = '1; tag = "R7/R9";
        end else if (mode == 0) tag = "R1";
        else tag = "R8";
        if (m_taken && rst_n && int'(tmode_code) != m_code) tag = {tag, "/R2"};
        check({tag, " bidi"}, {24'd0, eb_out, eb_oe}, {24'd0, bidi_out, bidi_oe});
        check({tag, (mode == 3) ? "/R6" : "", " outo"}, {38'd0, eo_out, eo_oe}, {38'd0, outo_out, outo_oe});
        check("R4 xtal", {63'd0, xtal_out}, {63'd0, core_xtal_out});
    endtask

    task automatic randomize_inputs();
        ded_in        = 10'($urandom);
        bidi_in       = 20'($urandom);
        core_bidi_out = 20'($urandom);
        core_bidi_oe  = 20'($urandom);
        core_outo_out = 13'($urandom);
        core_outo_oe  = 13'($urandom);
        core_xtal_out = 1'($urandom);
    endtask

    task automatic run(input logic [3:0] code, input int n, input logic [3:0] late_code, input bit mid_reset);
        @(negedge clk); compare();
        tmode_code = code; rst_n = 1'b0; randomize_inputs();
        repeat (3) begin @(negedge clk); compare(); randomize_inputs(); end
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); compare();
            randomize_inputs();
            if (i == n / 2) tmode_code = late_code;
            if (mid_reset && i == n - 4) rst_n = 1'b0;
        end
    endtask

    initial begin
        // R1 reset state
        #1; compare();
        run(4'b0000, 30, 4'b0010, 0);   // R2: 0010 without reset pulse stays normal
        run(4'b0010, 30, 4'b0000, 0);   // R3, R4
        run(4'b0011, 60, 4'b0100, 0);   // R5, R6, R9
        run(4'b0011, 20, 4'b0000, 1);   // R1: reset pulled inside tree mode
        run(4'b0100, 60, 4'b0011, 0);   // R7, R9
        run(4'b0001, 20, 4'b0010, 0);   // R8
        run(4'b0101, 20, 4'b0011, 0);   // R8
        run(4'b1111, 20, 4'b0100, 0);   // R8
        run(4'b0010, 20, 4'b0010, 0);   // R3 again after reserved
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule